// File: doc/BRIEF.md
# Dual-Mode PWM Timer

This block is an 8-bit timer that drives one pulse-width-modulated pin. The system clock passes through a prescaler, and the prescaler ticks advance a counter. The counter runs in one of two shapes. The single-slope shape counts upward and wraps. The dual-slope shape counts up to the ceiling and then back down to zero. A compare value is written into a holding register. The value moves into the live compare register only when the counter sits at its ceiling, so the duty cycle never changes partway through a period.

The pin level comes from a waveform register. That register is set or cleared when the count matches the live compare value, and in the single-slope shape also when the count wraps. A 2-bit polarity code selects true, inverted or parked (low) output. A sticky flag marks each counter turnaround and stays set until a clear strobe arrives. The block suits motor-drive and dimming loops in which software updates the duty value once per period.

Top module: `pwm8_timer`

## Requirements
- R1: After a synchronous reset, `pwm_out` and `ovf_flag` are 0, the counter is 0 and counting up, and both compare registers are 0. With single-slope mode and divide-by-1, the first flag set comes 255 clocks after reset is released.
- R2: `clk_sel` picks the tick rate: 0 gives every clock, 1 every 8th, 2 every 64th, 3 every 256th, and 4 to 7 every 1024th. The counter does not move between ticks.
- R3: When `mode_sel` is 0 (single slope), each tick adds one to the counter, and 255 steps to 0. A period lasts 256 ticks.
- R4: With single slope and `out_mode` 2 (true polarity), the pin rises on the tick that takes the count from 255 to 0 and falls on the tick that leaves a count equal to the live compare value C. It is high for C+1 ticks of every 256.
- R5: With single slope and `out_mode` 3 (inverted), the pin is the complement of R4 and is high for 255-C ticks of every 256.
- R6: In single slope with true polarity, C=0 gives a one-tick pulse every period and C=255 gives a steady high. With inverted polarity the levels are the reverse.
- R7: When `mode_sel` is 1 (dual slope), the counter climbs from 0 to 255 and then falls back to 0, stepping by one per tick. A period lasts 510 ticks.
- R8: In dual slope, a tick at which the count equals C clears the true-polarity waveform if that tick moves the count upward and sets it if the tick moves the count downward. The pin is high for 2C ticks of 510 in mode 2 and for 510-2C ticks in mode 3.
- R9: In dual slope with true polarity, C=0 holds the pin low and C=255 holds it high. Inverted polarity gives the reverse.
- R10: `out_mode` 0 or 1 drives `pwm_out` low from the next clock onward, in either counter shape.
- R11: A `cmp_wr` strobe loads only the holding register. The live compare value takes the held value on the tick that leaves a count of 255, in both shapes. A write partway through a period leaves the rest of that period unchanged.
- R12: `ovf_flag` is set by the tick that brings the count to 255 (single slope) or down to 0 (dual slope). It stays set until `flag_clr` is sampled high. A set event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 single-slope count, 1 dual-slope count |
| out_mode | input | 2 | 0/1 parked low, 2 true polarity, 3 inverted |
| clk_sel | input | 3 | Prescaler select, see R2 |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_data | input | CNT_W | Compare value to hold |
| flag_clr | input | 1 | Clears the turnaround flag |
| pwm_out | output | 1 | Modulated pin level |
| ovf_flag | output | 1 | Sticky turnaround flag |

## Verification
The duty function is tried with mid-range compare values in both polarities and both counter shapes, so that the single-slope C+1 law can be told apart from the dual-slope 2C law and true polarity from inverted. Compare values 0 and 255 separate the spike and steady-level corner cases from ordinary duty cycles. The parked codes 0 and 1 are given a value that would otherwise give a visible waveform. Runs at divide-by-8 and divide-by-64 show that pulse widths scale with the tick rate. Flag spacing tells the 256-tick period from the 510-tick period. A write partway through a period shows that the live compare value waits for the ceiling before it changes.

// File: rtl/pwm8_pkg.sv
`timescale 1ns/1ps
package pwm8_pkg;

    localparam int CNT_W_DEF = 8;
    localparam int PRE_W_DEF = 10;

    typedef enum logic {
        WAVE_SINGLE = 1'b0,
        WAVE_DUAL   = 1'b1
    } wave_mode_e;

    typedef enum logic [1:0] {
        OUT_OFF  = 2'd0,
        OUT_RSVD = 2'd1,
        OUT_NORM = 2'd2,
        OUT_INV  = 2'd3
    } out_mode_e;

    // Events produced by the counter for its neighbours.
    typedef struct packed {
        logic step_up;   // the step taken on this tick moves upward
        logic top_evt;   // tick while count is at the ceiling
        logic ovf_evt;   // tick that lands on the flag position
    } cnt_info_t;

    // Number of low prescaler bits that must all be one for a tick.
    function automatic int unsigned presc_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    return 0;
            3'd1:    return 3;
            3'd2:    return 6;
            3'd3:    return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic out_active(input out_mode_e m);
        return (m == OUT_NORM) || (m == OUT_INV);
    endfunction

endpackage

// File: rtl/pwm8_prescaler.sv
`timescale 1ns/1ps
module pwm8_prescaler
    import pwm8_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + PRE_W'(1);
    end

    always_comb begin
        mask = (PRE_W'(1) << presc_shift(sel)) - PRE_W'(1);
        tick = ((div_q & mask) == mask);
    end
endmodule

// File: rtl/pwm8_counter.sv
`timescale 1ns/1ps
module pwm8_counter
    import pwm8_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wave_mode_e       mode,
    output logic [CNT_W-1:0] cnt,
    output cnt_info_t        info
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    logic             up_q;
    logic             up_d;
    logic [CNT_W-1:0] cnt_d;
    logic             step_up;
    logic             lands_flag;

    always_comb begin
        cnt_d   = cnt;
        up_d    = up_q;
        step_up = 1'b1;
        if (mode == WAVE_SINGLE) begin
            cnt_d = cnt + CNT_W'(1);
            up_d  = 1'b1;
        end else if (up_q) begin
            if (cnt == TOP) begin
                step_up = 1'b0;
                cnt_d   = TOP - CNT_W'(1);
                up_d    = 1'b0;
            end else begin
                cnt_d = cnt + CNT_W'(1);
            end
        end else begin
            if (cnt == BOT) begin
                cnt_d = BOT + CNT_W'(1);
                up_d  = 1'b1;
            end else begin
                step_up = 1'b0;
                cnt_d   = cnt - CNT_W'(1);
            end
        end
        lands_flag   = (mode == WAVE_SINGLE) ? (cnt_d == TOP) : (cnt_d == BOT);
        info.step_up = step_up;
        info.top_evt = tick && (cnt == TOP);
        info.ovf_evt = tick && lands_flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= BOT;
            up_q <= 1'b1;
        end else if (tick) begin
            cnt  <= cnt_d;
            up_q <= up_d;
        end
    end
endmodule

// File: rtl/pwm8_cmpbuf.sv
`timescale 1ns/1ps
module pwm8_cmpbuf
    import pwm8_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             load,
    output logic [CNT_W-1:0] live
);
    logic [CNT_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            live   <= '0;
        end else begin
            if (wr)   hold_q <= wdata;
            if (load) live   <= hold_q;
        end
    end
endmodule

// File: rtl/pwm8_wavegen.sv
`timescale 1ns/1ps
module pwm8_wavegen
    import pwm8_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wave_mode_e       mode,
    input  out_mode_e        omode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ocr,
    input  logic             step_up,
    output logic             pwm
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // raw_q holds the true-polarity waveform whatever the output code is.
    logic raw_q;
    logic raw_d;

    always_comb begin
        raw_d = raw_q;
        if (tick) begin
            if (mode == WAVE_SINGLE) begin
                if (cnt == TOP)      raw_d = 1'b1;
                else if (cnt == ocr) raw_d = 1'b0;
            end else if (cnt == ocr) begin
                raw_d = ~step_up;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            pwm   <= 1'b0;
        end else begin
            raw_q <= raw_d;
            pwm   <= out_active(omode) ? (raw_d ^ (omode == OUT_INV)) : 1'b0;
        end
    end
endmodule

// File: rtl/pwm8_timer.sv
`timescale 1ns/1ps
module pwm8_timer
    import pwm8_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PRE_W = PRE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sel,
    input  logic [1:0]       out_mode,
    input  logic [2:0]       clk_sel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             flag_clr,
    output logic             pwm_out,
    output logic             ovf_flag
);
    wave_mode_e       wmode;
    out_mode_e        omode;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ocr_act;
    cnt_info_t        cinfo;
    logic             top_evt;
    logic             ovf_evt;

    assign wmode   = wave_mode_e'(mode_sel);
    assign omode   = out_mode_e'(out_mode);
    assign top_evt = cinfo.top_evt;
    assign ovf_evt = cinfo.ovf_evt;

    pwm8_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (clk_sel),
        .tick (tick)
    );

    pwm8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .mode (wmode),
        .cnt  (cnt),
        .info (cinfo)
    );

    pwm8_cmpbuf #(.CNT_W(CNT_W)) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .wr    (cmp_wr),
        .wdata (cmp_data),
        .load  (top_evt),
        .live  (ocr_act)
    );

    pwm8_wavegen #(.CNT_W(CNT_W)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (wmode),
        .omode   (omode),
        .cnt     (cnt),
        .ocr     (ocr_act),
        .step_up (cinfo.step_up),
        .pwm     (pwm_out)
    );

    // Sticky flag: a set event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)           ovf_flag <= 1'b0;
        else if (ovf_evt)  ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/pwm8_timer_chk.sv
`timescale 1ns/1ps
module pwm8_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             mode_sel,
    input logic [1:0]       out_mode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ocr_act,
    input logic             top_evt,
    input logic             ovf_evt,
    input logic             flag_clr,
    input logic             ovf_flag,
    input logic             pwm_out
);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !mode_sel) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_dual_step_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && mode_sel) |=> ((cnt == $past(cnt) + CNT_W'(1)) ||
                                (cnt == $past(cnt) - CNT_W'(1))));

    p_parked_low_r10: assert property (@(posedge clk) disable iff (rst)
        (out_mode[1] == 1'b0) |=> !pwm_out);

    p_live_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !top_evt |=> $stable(ocr_act));

    p_flag_set_r12: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    p_flag_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    p_flag_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !ovf_evt) |=> !ovf_flag);
endmodule

bind pwm8_timer pwm8_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mode_sel (mode_sel),
    .out_mode (out_mode),
    .cnt      (cnt),
    .ocr_act  (ocr_act),
    .top_evt  (top_evt),
    .ovf_evt  (ovf_evt),
    .flag_clr (flag_clr),
    .ovf_flag (ovf_flag),
    .pwm_out  (pwm_out)
);

// File: tb/pwm8_timer_tb.sv
`timescale 1ns/1ps
module pwm8_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic [1:0] out_mode = 2'd2;
    logic [2:0] clk_sel = 3'd0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_data = 8'd0;
    logic       flag_clr = 1'b0;
    logic       pwm_out;
    logic       ovf_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    pwm8_timer u_dut (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .out_mode (out_mode),
        .clk_sel  (clk_sel),
        .cmp_wr   (cmp_wr),
        .cmp_data (cmp_data),
        .flag_clr (flag_clr),
        .pwm_out  (pwm_out),
        .ovf_flag (ovf_flag)
    );

    typedef struct packed {
        logic       wm;
        logic [1:0] om;
        logic [7:0] cv;
        logic [2:0] ps;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 8'd100, 3'd0},   // R4
        '{1'b0, 2'd3, 8'd100, 3'd0},   // R5
        '{1'b0, 2'd2, 8'd0,   3'd0},   // R6 spike
        '{1'b0, 2'd2, 8'd255, 3'd0},   // R6 steady high
        '{1'b0, 2'd3, 8'd0,   3'd0},   // R6 inverted spike
        '{1'b0, 2'd3, 8'd255, 3'd0},   // R6 steady low
        '{1'b0, 2'd0, 8'd100, 3'd0},   // R10
        '{1'b0, 2'd1, 8'd100, 3'd0},   // R10
        '{1'b1, 2'd2, 8'd100, 3'd0},   // R8
        '{1'b1, 2'd3, 8'd100, 3'd0},   // R8
        '{1'b1, 2'd2, 8'd0,   3'd0},   // R9
        '{1'b1, 2'd2, 8'd255, 3'd0},   // R9
        '{1'b1, 2'd3, 8'd0,   3'd0},   // R9
        '{1'b1, 2'd3, 8'd255, 3'd0},   // R9
        '{1'b1, 2'd1, 8'd60,  3'd0},   // R10
        '{1'b0, 2'd2, 8'd40,  3'd1},   // R2 /8
        '{1'b1, 2'd3, 8'd30,  3'd1},   // R2 /8
        '{1'b0, 2'd2, 8'd3,   3'd2}    // R2 /64
    };

    function automatic int div_of(input logic [2:0] ps);
        case (ps)
            3'd0:    return 1;
            3'd1:    return 8;
            3'd2:    return 64;
            3'd3:    return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic int period_ticks(input logic wm);
        return wm ? 510 : 256;
    endfunction

    function automatic int exp_high(input vec_t v);
        int c;
        int t;
        c = int'(v.cv);
        if (v.om < 2)       t = 0;
        else if (!v.wm)     t = (v.om == 2'd2) ? (c + 1) : (255 - c);
        else                t = (v.om == 2'd2) ? (2 * c) : (510 - 2 * c);
        return t * div_of(v.ps);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    task automatic write_cmp(input logic [7:0] v);
        cmp_data = v;
        cmp_wr   = 1'b1;
        @(negedge clk);
        cmp_wr   = 1'b0;
    endtask

    // Sync on a flag set, then count clocks to the next one.
    task automatic flag_gap(input string req, output int n);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        while (!ovf_flag) @(negedge clk);
        flag_clr = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            flag_clr = 1'b0;
            if (n == 1) check(!ovf_flag, "R12 clear", int'(ovf_flag), 0);
        end while (!ovf_flag && n < 3000);
        check(n > 0, req, n, n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        int n;
        int h;
        int per;
        vec_t v;

        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1 pwm in reset", int'(pwm_out), 0);
        check(ovf_flag == 1'b0, "R1 flag in reset", int'(ovf_flag), 0);

        // R1: counter starts at 0, first flag after 255 clocks
        rst = 1'b0;
        n = 0;
        while (!ovf_flag && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(n == 255, "R1 first flag", n, 255);

        // R3 / R12: single-slope flag spacing
        flag_gap("R3 period", n);
        check(n == 256, "R3 flag spacing", n, 256);

        // R12: set outranks clear in the same cycle
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(!ovf_flag, "R12 cleared", int'(ovf_flag), 0);
        repeat (254) @(negedge clk);
        check(!ovf_flag, "R12 still clear", int'(ovf_flag), 0);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(ovf_flag, "R12 set wins", int'(ovf_flag), 1);

        // R7: dual-slope flag spacing
        mode_sel = 1'b1;
        repeat (600) @(negedge clk);
        flag_gap("R7 period", n);
        check(n == 510, "R7 flag spacing", n, 510);

        // Table walk: duty per configuration
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            mode_sel = v.wm;
            out_mode = v.om;
            clk_sel  = v.ps;
            write_cmp(v.cv);
            per = period_ticks(v.wm) * div_of(v.ps);
            repeat (2 * per) @(negedge clk);
            h = 0;
            for (int k = 0; k < per; k++) begin
                @(negedge clk);
                h += int'(pwm_out);
            end
            check(h == exp_high(v), $sformatf("R4-style duty vec %0d (R%0d)", i,
                  (v.om < 2) ? 10 : (v.ps != 0) ? 2 : (!v.wm) ? 4 : 8), h, exp_high(v));
        end

        // R11: mid-period write waits for the ceiling
        mode_sel = 1'b0;
        out_mode = 2'd2;
        clk_sel  = 3'd0;
        write_cmp(8'd200);
        repeat (600) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        while (!ovf_flag) @(negedge clk);
        repeat (50) @(negedge clk);
        write_cmp(8'd10);
        repeat (50) @(negedge clk);
        check(pwm_out == 1'b1, "R11 old value kept", int'(pwm_out), 1);
        repeat (161) @(negedge clk);
        check(pwm_out == 1'b1, "R11 new period start", int'(pwm_out), 1);
        repeat (95) @(negedge clk);
        check(pwm_out == 1'b0, "R11 new value live", int'(pwm_out), 0);

        report();
        $finish;
    end
endmodule